// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block puts a byte-wide configuration register space behind two bus addresses. A byte written to the first address (the index port) selects a register, and a read or write at the second address (the data port) reaches that register. The space stays closed until the host writes a fixed unlock byte twice in a row to the index port. A separate lock byte closes it again. While the space is closed, the data port ignores writes and both ports read back as all ones.

Indices below 0x30 hold global registers. These are a logical-device selector, read-only identity constants and a few scratch bytes. Indices 0x30 and above belong to whichever logical device the selector names. Index 0x30 of every device holds that device's enable bit, which is driven out as one line per device. For one chosen device, every other index from 0x31 upward is passed to an attached peripheral through a simple strobe, address and data port. System address decode and resource assignment sit outside this block.

Top module: `cfg_keyed_port`

## Requirements
- R1: After reset the space is locked, the index and device-selector registers are 0x00, the scratch registers are 0x00 and every device enable output is 0.
- R2: Two consecutive index-port writes of 0x87 open the space. Neither unlock byte is loaded into the index. While open, a read of the index port returns the current index.
- R3: Any index-port write other than 0x87 between the two unlock bytes restarts the sequence, so a further pair of 0x87 writes is required.
- R4: While locked, data-port writes change no register and no enable output, and reads of either port return 0xFF.
- R5: While open, an index-port write of 0xAA locks the space and leaves the index unchanged. Any other index-port byte is loaded as the index.
- R6: Indices 0x20 and 0x21 return the device identifier, high byte first. Index 0x22 returns the revision. Indices 0x23 and 0x24 return the vendor identifier, high byte first. Writes to these five indices have no effect.
- R7: Index 0x07 is a readable and writable 8-bit logical-device selector.
- R8: Index 0x30 stores bit 0 as the enable of the selected device (output bit n for device n). The other bits read as 0. A selector at or above the device count stores nothing.
- R9: When the selector equals the exported device number (default 7), a data-port access at index 0x31 or above produces a one-cycle dev_wr or dev_rd with dev_addr equal to the index. Reads return dev_rdata. No strobe occurs for any other selector value or while locked.
- R10: Indices 0x28 to 0x2B are readable and writable scratch bytes.
- R11: Unassigned indices of the global range and of non-exported devices read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe, one cycle per byte |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte, valid in the cycle of bus_rd |
| dev_enable | output | NUM_DEV | Enable bit of each logical device |
| dev_wr | output | 1 | Write strobe to the exported device bank |
| dev_rd | output | 1 | Read strobe to the exported device bank |
| dev_addr | output | 8 | Register index within the exported bank |
| dev_wdata | output | 8 | Write byte to the exported bank |
| dev_rdata | input | 8 | Read byte from the exported bank |

## Verification
The hardest case to reach is an unlock sequence broken partway through. Such a sequence looks locked both before and after the stray byte, so the stimulus writes 0x87, a different byte and 0x87 again. It then confirms the space is still locked before a final 0x87 opens it. A second difficult case is confirming that writes made while locked changed nothing. The bench does this by unlocking afterwards and reading back the selector and the enable outputs. Forwarding is checked by switching the selector between the exported device and another device while watching the strobe pins.

// File: rtl/cfg_keyed_port_pkg.sv
package cfg_keyed_port_pkg;
   localparam logic [7:0] KEY_OPEN     = 8'h87;
   localparam logic [7:0] KEY_CLOSE    = 8'hAA;
   localparam logic [7:0] IDX_LDSEL    = 8'h07;
   localparam logic [7:0] IDX_DEVID_HI = 8'h20;
   localparam logic [7:0] IDX_DEVID_LO = 8'h21;
   localparam logic [7:0] IDX_REV      = 8'h22;
   localparam logic [7:0] IDX_VEND_HI  = 8'h23;
   localparam logic [7:0] IDX_VEND_LO  = 8'h24;
   localparam logic [7:0] IDX_SCRATCH  = 8'h28;
   localparam logic [7:0] IDX_DEV_BASE = 8'h30;

   typedef enum logic [1:0] {
      KS_SHUT = 2'd0,
      KS_HALF = 2'd1,
      KS_OPEN = 2'd2
   } key_state_e;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
   import cfg_keyed_port_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic [7:0] wbyte,
   output logic       open
);
   key_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (idx_wr) begin
         unique case (state_q)
            KS_SHUT: state_d = (wbyte == KEY_OPEN)  ? KS_HALF : KS_SHUT;
            KS_HALF: state_d = (wbyte == KEY_OPEN)  ? KS_OPEN : KS_SHUT;
            KS_OPEN: state_d = (wbyte == KEY_CLOSE) ? KS_SHUT : KS_OPEN;
            default: state_d = KS_SHUT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= KS_SHUT;
      else        state_q <= state_d;
   end

   assign open = (state_q == KS_OPEN);
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
   import cfg_keyed_port_pkg::*;
#(
   parameter logic [15:0] DEV_ID      = 16'h5A31,
   parameter logic [7:0]  DEV_REV     = 8'h12,
   parameter logic [15:0] VENDOR_ID   = 16'hC0DE,
   parameter int          NUM_SCRATCH = 4
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] index,
   input  logic [7:0] wbyte,
   output logic [7:0] rbyte,
   output logic [7:0] ldsel
);
   initial begin
      if (NUM_SCRATCH < 1 || NUM_SCRATCH > 8)
         $error("NUM_SCRATCH must lie in 1..8");
   end

   logic [7:0] ldsel_q;
   logic [7:0] scr_q [NUM_SCRATCH];
   logic [NUM_SCRATCH-1:0] scr_hit;

   always_ff @(posedge clk) begin
      if (!rst_n)                          ldsel_q <= '0;
      else if (wr_en && index == IDX_LDSEL) ldsel_q <= wbyte;
   end

   for (genvar g = 0; g < NUM_SCRATCH; g++) begin : g_scr
      assign scr_hit[g] = (index == IDX_SCRATCH + 8'(g));
      always_ff @(posedge clk) begin
         if (!rst_n)                   scr_q[g] <= '0;
         else if (wr_en && scr_hit[g]) scr_q[g] <= wbyte;
      end
   end

   always_comb begin
      rbyte = 8'h00;
      unique case (index)
         IDX_LDSEL:    rbyte = ldsel_q;
         IDX_DEVID_HI: rbyte = DEV_ID[15:8];
         IDX_DEVID_LO: rbyte = DEV_ID[7:0];
         IDX_REV:      rbyte = DEV_REV;
         IDX_VEND_HI:  rbyte = VENDOR_ID[15:8];
         IDX_VEND_LO:  rbyte = VENDOR_ID[7:0];
         default: begin
            for (int k = 0; k < NUM_SCRATCH; k++)
               if (scr_hit[k]) rbyte = scr_q[k];
         end
      endcase
   end

   assign ldsel = ldsel_q;
endmodule

// File: rtl/cfg_dev_enables.sv
module cfg_dev_enables #(
   parameter int NUM_DEV = 8
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [7:0]         sel,
   input  logic               wbit,
   output logic [NUM_DEV-1:0] en,
   output logic               rbit
);
   localparam int SEL_W = $clog2(NUM_DEV);

   initial begin
      if (NUM_DEV < 2 || NUM_DEV > 256)
         $error("NUM_DEV must lie in 2..256");
   end

   logic sel_ok;
   assign sel_ok = (int'(sel) < NUM_DEV);

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_en
      always_ff @(posedge clk) begin
         if (!rst_n)
            en[d] <= 1'b0;
         else if (wr_en && sel_ok && int'(sel) == d)
            en[d] <= wbit;
      end
   end

   assign rbit = sel_ok ? en[sel[SEL_W-1:0]] : 1'b0;
endmodule

// File: rtl/cfg_keyed_port.sv
module cfg_keyed_port
   import cfg_keyed_port_pkg::*;
#(
   parameter int          NUM_DEV     = 8,
   parameter int          EXPORT_LDN  = 7,
   parameter int          NUM_SCRATCH = 4,
   parameter logic [15:0] DEV_ID      = 16'h5A31,
   parameter logic [7:0]  DEV_REV     = 8'h12,
   parameter logic [15:0] VENDOR_ID   = 16'hC0DE
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic               bus_addr,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   output logic [NUM_DEV-1:0] dev_enable,
   output logic               dev_wr,
   output logic               dev_rd,
   output logic [7:0]         dev_addr,
   output logic [7:0]         dev_wdata,
   input  logic [7:0]         dev_rdata
);
   localparam logic [7:0] EXP_SEL = 8'(EXPORT_LDN);

   initial begin
      if (EXPORT_LDN < 0 || EXPORT_LDN >= NUM_DEV)
         $error("EXPORT_LDN must name an existing device");
   end

   logic       cfg_open;
   logic [7:0] index_q;
   logic [7:0] ldsel;
   logic [7:0] glb_rbyte;
   logic       en_rbit;
   logic       idx_wr, dat_wr;
   logic       in_dev, at_en, fwd_hit;

   assign idx_wr  = bus_wr && !bus_addr;
   assign dat_wr  = bus_wr &&  bus_addr && cfg_open;
   assign in_dev  = (index_q >= IDX_DEV_BASE);
   assign at_en   = (index_q == IDX_DEV_BASE);
   assign fwd_hit = cfg_open && in_dev && !at_en && (ldsel == EXP_SEL);

   cfg_key_fsm u_key (
      .clk   (clk),
      .rst_n (rst_n),
      .idx_wr(idx_wr),
      .wbyte (bus_wdata),
      .open  (cfg_open)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         index_q <= '0;
      else if (idx_wr && cfg_open && bus_wdata != KEY_CLOSE)
         index_q <= bus_wdata;
   end

   cfg_global_regs #(
      .DEV_ID     (DEV_ID),
      .DEV_REV    (DEV_REV),
      .VENDOR_ID  (VENDOR_ID),
      .NUM_SCRATCH(NUM_SCRATCH)
   ) u_glb (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(dat_wr && !in_dev),
      .index(index_q),
      .wbyte(bus_wdata),
      .rbyte(glb_rbyte),
      .ldsel(ldsel)
   );

   cfg_dev_enables #(.NUM_DEV(NUM_DEV)) u_en (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(dat_wr && at_en),
      .sel  (ldsel),
      .wbit (bus_wdata[0]),
      .en   (dev_enable),
      .rbit (en_rbit)
   );

   assign dev_wr    = bus_wr && bus_addr && fwd_hit;
   assign dev_rd    = bus_rd && bus_addr && fwd_hit;
   assign dev_addr  = index_q;
   assign dev_wdata = bus_wdata;

   always_comb begin
      if (!cfg_open)      bus_rdata = 8'hFF;
      else if (!bus_addr) bus_rdata = index_q;
      else if (!in_dev)   bus_rdata = glb_rbyte;
      else if (at_en)     bus_rdata = {7'b0, en_rbit};
      else if (fwd_hit)   bus_rdata = dev_rdata;
      else                bus_rdata = 8'h00;
   end
endmodule

// File: rtl/cfg_keyed_port_chk.sv
module cfg_keyed_port_chk #(
   parameter int NUM_DEV    = 8,
   parameter int EXPORT_LDN = 7
)(
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic               bus_rd,
   input logic               bus_addr,
   input logic [7:0]         bus_wdata,
   input logic [7:0]         bus_rdata,
   input logic               dev_wr,
   input logic               dev_rd,
   input logic [NUM_DEV-1:0] dev_enable,
   input logic               cfg_open,
   input logic [7:0]         ldsel
);
   // R2: opening is always caused by an unlock byte on the index port
   p_open_by_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_open) |-> $past(bus_wr && !bus_addr && bus_wdata == 8'h87));

   // R4: locked reads return all ones
   p_locked_reads_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_open && bus_rd) |-> bus_rdata == 8'hFF);

   // R4: enables cannot change while locked
   p_locked_en_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_open |=> $stable(dev_enable));

   // R5: lock byte closes the space
   p_lock_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && bus_wr && !bus_addr && bus_wdata == 8'hAA) |=> !cfg_open);

   // R9: strobes only when open and the exported device is selected
   p_fwd_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_wr || dev_rd) |-> (cfg_open && ldsel == 8'(EXPORT_LDN)));

   // R9: at most one strobe at a time
   p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dev_wr, dev_rd}));
endmodule

bind cfg_keyed_port cfg_keyed_port_chk #(
   .NUM_DEV   (NUM_DEV),
   .EXPORT_LDN(EXPORT_LDN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .dev_wr    (dev_wr),
   .dev_rd    (dev_rd),
   .dev_enable(dev_enable),
   .cfg_open  (cfg_open),
   .ldsel     (ldsel)
);

// File: tb/tb_cfg_keyed_port.sv
module tb_cfg_keyed_port;
   localparam int NDEV = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
   logic [7:0]      bus_wdata = '0;
   logic [7:0]      bus_rdata;
   logic [NDEV-1:0] dev_enable;
   logic            dev_wr, dev_rd;
   logic [7:0]      dev_addr, dev_wdata, dev_rdata;
   logic [7:0]      pmem [256];

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   logic seen_wr, seen_rd;

   always #10 clk = ~clk;

   cfg_keyed_port dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dev_enable(dev_enable), .dev_wr(dev_wr), .dev_rd(dev_rd),
      .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
   );

   // peripheral model for the exported bank
   always @(posedge clk) if (dev_wr) pmem[dev_addr] <= dev_wdata;
   assign dev_rdata = pmem[dev_addr] ^ 8'h00;

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic wr(input logic port, input logic [7:0] b);
      @(negedge clk);
      bus_addr = port; bus_wdata = b; bus_wr = 1'b1;
      #2 seen_wr = dev_wr; seen_rd = dev_rd;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic port, output logic [7:0] b);
      @(negedge clk);
      bus_addr = port; bus_rd = 1'b1;
      #2 b = bus_rdata; seen_rd = dev_rd; seen_wr = dev_wr;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // vector: {req[3:0], is_read, port, data, expected}
   localparam int NV = 44;
   localparam logic [21:0] VEC [NV] = '{
      {4'd1,  1'b1, 1'b0, 8'h00, 8'hFF},  // R1 locked index port
      {4'd4,  1'b1, 1'b1, 8'h00, 8'hFF},  // R4 locked data port
      {4'd4,  1'b0, 1'b1, 8'h03, 8'h00},  // R4 data write while locked
      {4'd3,  1'b0, 1'b0, 8'h87, 8'h00},
      {4'd3,  1'b1, 1'b0, 8'h00, 8'hFF},  // R3 half way still locked
      {4'd3,  1'b0, 1'b0, 8'h55, 8'h00},
      {4'd3,  1'b0, 1'b0, 8'h87, 8'h00},
      {4'd3,  1'b1, 1'b0, 8'h00, 8'hFF},  // R3 broken sequence
      {4'd2,  1'b0, 1'b0, 8'h87, 8'h00},
      {4'd2,  1'b1, 1'b0, 8'h00, 8'h00},  // R2 open, index untouched
      {4'd11, 1'b1, 1'b1, 8'h00, 8'h00},  // R11 index 0 reads zero
      {4'd7,  1'b0, 1'b0, 8'h07, 8'h00},
      {4'd4,  1'b1, 1'b1, 8'h00, 8'h00},  // R4 locked write ignored
      {4'd7,  1'b0, 1'b1, 8'h05, 8'h00},
      {4'd7,  1'b1, 1'b1, 8'h00, 8'h05},  // R7 selector
      {4'd6,  1'b0, 1'b0, 8'h20, 8'h00},
      {4'd6,  1'b0, 1'b1, 8'h00, 8'h00},
      {4'd6,  1'b1, 1'b1, 8'h00, 8'h5A},  // R6 device id high
      {4'd6,  1'b0, 1'b0, 8'h21, 8'h00},
      {4'd6,  1'b1, 1'b1, 8'h00, 8'h31},  // R6 device id low
      {4'd6,  1'b0, 1'b0, 8'h22, 8'h00},
      {4'd6,  1'b1, 1'b1, 8'h00, 8'h12},  // R6 revision
      {4'd6,  1'b0, 1'b0, 8'h23, 8'h00},
      {4'd6,  1'b1, 1'b1, 8'h00, 8'hC0},  // R6 vendor high
      {4'd6,  1'b0, 1'b0, 8'h24, 8'h00},
      {4'd6,  1'b0, 1'b1, 8'hFF, 8'h00},
      {4'd6,  1'b1, 1'b1, 8'h00, 8'hDE},  // R6 vendor low
      {4'd10, 1'b0, 1'b0, 8'h28, 8'h00},
      {4'd10, 1'b0, 1'b1, 8'hA5, 8'h00},
      {4'd10, 1'b0, 1'b0, 8'h2B, 8'h00},
      {4'd10, 1'b0, 1'b1, 8'h3C, 8'h00},
      {4'd10, 1'b1, 1'b1, 8'h00, 8'h3C},  // R10 last scratch
      {4'd10, 1'b0, 1'b0, 8'h28, 8'h00},
      {4'd10, 1'b1, 1'b1, 8'h00, 8'hA5},  // R10 first scratch
      {4'd11, 1'b0, 1'b0, 8'h2C, 8'h00},
      {4'd11, 1'b1, 1'b1, 8'h00, 8'h00},  // R11 unassigned global
      {4'd8,  1'b0, 1'b0, 8'h30, 8'h00},
      {4'd8,  1'b0, 1'b1, 8'hFF, 8'h00},
      {4'd8,  1'b1, 1'b1, 8'h00, 8'h01},  // R8 enable bit only
      {4'd5,  1'b0, 1'b0, 8'hAA, 8'h00},
      {4'd5,  1'b1, 1'b0, 8'h00, 8'hFF},  // R5 locked again
      {4'd2,  1'b0, 1'b0, 8'h87, 8'h00},
      {4'd2,  1'b0, 1'b0, 8'h87, 8'h00},
      {4'd5,  1'b1, 1'b0, 8'h00, 8'h30}   // R5 index kept across lock
   };

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 enables", 32'(dev_enable), 32'h0);
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][17]) begin
            rd(VEC[i][16], r);
            chk($sformatf("R%0d vec%0d", VEC[i][21:18], i), 32'(r), 32'(VEC[i][7:0]));
         end else begin
            wr(VEC[i][16], VEC[i][15:8]);
         end
      end
      // R8: selector 5 got its enable
      chk("R8 enable out", 32'(dev_enable), 32'h20);
      // R8: selector beyond device count stores nothing
      wr(0, 8'h07); wr(1, 8'h0C); wr(0, 8'h30); wr(1, 8'h01);
      rd(1, r); chk("R8 out of range read", 32'(r), 32'h0);
      chk("R8 out of range no effect", 32'(dev_enable), 32'h20);
      // R9: exported device forwarding
      wr(0, 8'h07); wr(1, 8'h07); wr(0, 8'h41);
      wr(1, 8'h99);
      chk("R9 dev_wr pulse", 32'(seen_wr), 32'h1);
      rd(1, r);
      chk("R9 read data", 32'(r), 32'h99);
      chk("R9 dev_rd pulse", 32'(seen_rd), 32'h1);
      // R9: index 0x30 of exported device stays local
      wr(0, 8'h30); wr(1, 8'h01);
      chk("R9 enable not forwarded", 32'(seen_wr), 32'h0);
      chk("R8 exported enable", 32'(dev_enable), 32'hA0);
      // R9: other device gets no strobe, reads zero (R11)
      wr(0, 8'h07); wr(1, 8'h05); wr(0, 8'h41);
      wr(1, 8'h77);
      chk("R9 no strobe other dev", 32'(seen_wr), 32'h0);
      rd(1, r);
      chk("R11 non-exported reads zero", 32'(r), 32'h0);
      chk("R9 no read strobe other dev", 32'(seen_rd), 32'h0);
      // R4/R9: locked, no forwarding
      wr(0, 8'h07); wr(1, 8'h07); wr(0, 8'h41); wr(0, 8'hAA);
      wr(1, 8'h11);
      chk("R4 no strobe locked", 32'(seen_wr), 32'h0);
      wr(0, 8'h87); wr(0, 8'h87);
      rd(1, r); chk("R4 bank unchanged", 32'(r), 32'h99);
      // R1: reset mid-session
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd(0, r); chk("R1 locked after reset", 32'(r), 32'hFF);
      chk("R1 enables cleared", 32'(dev_enable), 32'h0);
      wr(0, 8'h87); wr(0, 8'h87);
      rd(0, r); chk("R1 index cleared", 32'(r), 32'h0);
      wr(0, 8'h07); rd(1, r); chk("R1 selector cleared", 32'(r), 32'h0);
      wr(0, 8'h2B); rd(1, r); chk("R1 scratch cleared", 32'(r), 32'h0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule